// File: doc/BRIEF.md
# Saturating Branch Sample Recorder

This block captures the source and destination addresses of retired taken branches into a small buffer of slots. Capture runs only while an enable bit is set. The buffer fills in a single pass from slot 0 upward. When the last slot has been written, the block stops on its own and clears the enable bit. It never wraps and never overwrites older samples.

A performance counter is associated with the block through a counter-select field in the control word. When that counter overflows during a capture, its interrupt is not forwarded at once. The interrupt is held until the buffer is full, or until software clears the enable bit, and is then delivered as a one-cycle pulse. In this way, the branch history captured around a sampling event always goes out together with the interrupt.

Software reaches the control word and every slot through one register port. The port has a combinational read path and a write strobe. Software uses the port to arm a fresh capture, to read the captured history, and to overwrite individual slots, for example with a marker value.

Top module: `branch_sample_recorder`

## Requirements
- R1: After reset, the control word at address 32 reads 0x18, every slot register reads 0, and `irq_out` is low.
- R2: Control word layout. Bit 2 is the enable bit. Bits 4:3 always read as binary 11. Bit 5 is the valid flag. Bits 19:16 are the next-slot index. Bits 26:24 are the counter select. All other bits read 0. A write to address 32 loads the enable, valid, index and counter-select fields exactly as written.
- R3: A retired taken branch (`br_retire` high) is recorded whenever the enable bit is set, with no filtering of any kind. It is stored in the slot named by the index. Its source reads at address 2*i and its destination at address 2*i+1.
- R4: Each recorded branch advances the index by one and sets the valid flag. The valid flag changes only through a control word write.
- R5: When the branch in slot 15 is recorded, the index returns to 0 and the enable bit clears by itself. After that, further branches change neither the slots nor the control word.
- R6: A counter overflow that arrives while capture is enabled is held. It appears on `irq_out` as a one-cycle pulse in the cycle after the buffer becomes full. `irq_out` is never high while the enable bit is set.
- R7: If software clears the enable bit while an overflow is held, the pulse follows in the next cycle. The valid flag and the index keep the values software wrote back.
- R8: Bits 63:61 of every stored destination read as 0. This applies to destinations written by capture and to destinations written by software.
- R9: With capture disabled, an overflow on the counter line chosen by the counter-select field gives a one-cycle `irq_out` pulse in the next cycle. Overflows on the other lines are ignored.
- R10: If a control word write and a branch fall in the same cycle, the write is applied first. The branch is recorded into the newly written index only if the written enable bit is 1.
- R11: Software writes to addresses 0 to 31 replace the addressed slot register. Writes to addresses 33 to 63 have no effect, and those addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| br_retire | input | 1 | A taken branch retires this cycle |
| br_src | input | 64 | Source address of the retiring branch |
| br_dst | input | 64 | Destination address of the retiring branch |
| cnt_ovf | input | 6 | Overflow pulses, one line per performance counter |
| reg_addr | input | 6 | Register port address (slots 0..31, control word 32) |
| reg_we | input | 1 | Register port write strobe |
| reg_wdata | input | 64 | Register port write data |
| reg_rdata | output | 64 | Register port read data (combinational) |
| irq_out | output | 1 | Delivered counter interrupt, one-cycle pulse |

## Verification
The bench fills all sixteen slots and then sends one more branch. A recorder that wrapped instead of saturating would overwrite slot 0. One that did not clear its enable bit would show enable still set with index 0. It also raises an overflow at the moment capture is armed and watches `irq_out` through fifteen branches. A design that forwarded the overflow early, or lost it, would pulse too soon or never pulse at all. Software then clears the enable bit part way through a capture. A missing release would leave the interrupt stuck, and a read-modify-write error would corrupt the index or the valid flag. Finally, a control word write and a branch are applied in the same cycle. The wrong priority would either record a branch after disable or write it into the old slot.

// File: rtl/brs_pkg.sv
package brs_pkg;
  localparam int XLEN        = 64;
  localparam int IDX_W       = 4;
  localparam int PMC_W       = 3;
  localparam int ADDR_W      = IDX_W + 2;
  localparam int CFG_EN_BIT  = 2;
  localparam int CFG_VB_BIT  = 5;
  localparam int CFG_IDX_LSB = 16;
  localparam int CFG_PMC_LSB = 24;
  localparam int TGT_KEEP_W  = 61;

  localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(1 << (ADDR_W - 1));

  function automatic logic [XLEN-1:0] tgt_clean(input logic [XLEN-1:0] a);
    return {{(XLEN - TGT_KEEP_W){1'b0}}, a[TGT_KEEP_W-1:0]};
  endfunction

  function automatic logic [XLEN-1:0] cfg_word(input logic en, input logic vb,
                                               input logic [IDX_W-1:0] idx,
                                               input logic [PMC_W-1:0] pmc);
    logic [XLEN-1:0] w;
    w = '0;
    w[4:3] = 2'b11;
    w[CFG_EN_BIT] = en;
    w[CFG_VB_BIT] = vb;
    w[CFG_IDX_LSB +: IDX_W] = idx;
    w[CFG_PMC_LSB +: PMC_W] = pmc;
    return w;
  endfunction
endpackage

// File: rtl/brs_ctrl.sv
module brs_ctrl
  import brs_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int NUM_CNT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [XLEN-1:0]  cfg_wdata,
  input  logic             br_retire,
  input  logic [NUM_CNT-1:0] cnt_ovf,
  output logic             en_o,
  output logic             vb_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [PMC_W-1:0] pmc_o,
  output logic             rec_we_o,
  output logic [IDX_W-1:0] rec_idx_o,
  output logic             held_o,
  output logic             irq_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic             en_q, vb_q, held_q, irq_q;
  logic [IDX_W-1:0] idx_q;
  logic [PMC_W-1:0] pmc_q;

  logic             en_w, vb_w, en_n, vb_n, held_n, irq_n;
  logic [IDX_W-1:0] idx_w, idx_n;
  logic [PMC_W-1:0] pmc_n;
  logic             rec, ovf_sel, pend, state_ce;

  // control word write lands before the branch of the same cycle
  always_comb begin
    en_w  = cfg_we ? cfg_wdata[CFG_EN_BIT] : en_q;
    vb_w  = cfg_we ? cfg_wdata[CFG_VB_BIT] : vb_q;
    idx_w = cfg_we ? cfg_wdata[CFG_IDX_LSB +: IDX_W] : idx_q;
    pmc_n = cfg_we ? cfg_wdata[CFG_PMC_LSB +: PMC_W] : pmc_q;
    rec   = br_retire & en_w;
    en_n  = en_w;
    vb_n  = vb_w;
    idx_n = idx_w;
    if (rec) begin
      vb_n = 1'b1;
      if (idx_w == LAST_IDX) begin
        idx_n = '0;
        en_n  = 1'b0;
      end else begin
        idx_n = idx_w + IDX_W'(1);
      end
    end
  end

  // overflow line picked by the stored counter select
  always_comb begin
    ovf_sel = 1'b0;
    for (int c = 0; c < NUM_CNT; c++) begin
      if (pmc_q == PMC_W'(c)) ovf_sel = cnt_ovf[c];
    end
    pend   = held_q | ovf_sel;
    held_n = pend & en_n;
    irq_n  = pend & ~en_n;
  end

  assign state_ce = cfg_we | rec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      vb_q   <= 1'b0;
      idx_q  <= '0;
      pmc_q  <= '0;
      held_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (state_ce) begin
        en_q  <= en_n;
        vb_q  <= vb_n;
        idx_q <= idx_n;
      end
      if (cfg_we) pmc_q <= pmc_n;
      held_q <= held_n;
      irq_q  <= irq_n;
    end
  end

  assign en_o      = en_q;
  assign vb_o      = vb_q;
  assign idx_o     = idx_q;
  assign pmc_o     = pmc_q;
  assign rec_we_o  = rec;
  assign rec_idx_o = idx_w;
  assign held_o    = held_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/brs_store.sv
module brs_store
  import brs_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rec_we,
  input  logic [IDX_W-1:0]            rec_idx,
  input  logic [XLEN-1:0]             rec_src,
  input  logic [XLEN-1:0]             rec_dst,
  input  logic                        sw_we,
  input  logic [IDX_W-1:0]            sw_slot,
  input  logic                        sw_sel_dst,
  input  logic [XLEN-1:0]             sw_wdata,
  output logic [DEPTH-1:0][XLEN-1:0]  src_q,
  output logic [DEPTH-1:0][XLEN-1:0]  dst_q
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic            rec_hit, sw_hit, src_ce, dst_ce;
    logic [XLEN-1:0] src_d, dst_d;

    // capture wins over a software write to the same slot
    assign rec_hit = rec_we && (rec_idx == IDX_W'(g));
    assign sw_hit  = sw_we && (sw_slot == IDX_W'(g));
    assign src_ce  = rec_hit | (sw_hit & ~sw_sel_dst);
    assign dst_ce  = rec_hit | (sw_hit & sw_sel_dst);
    assign src_d   = rec_hit ? rec_src : sw_wdata;
    assign dst_d   = tgt_clean(rec_hit ? rec_dst : sw_wdata);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_q[g] <= '0;
        dst_q[g] <= '0;
      end else begin
        if (src_ce) src_q[g] <= src_d;
        if (dst_ce) dst_q[g] <= dst_d;
      end
    end
  end
endmodule

// File: rtl/brs_rdmux.sv
module brs_rdmux
  import brs_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DEPTH-1:0][XLEN-1:0]  src_q,
  input  logic [DEPTH-1:0][XLEN-1:0]  dst_q,
  input  logic                        en,
  input  logic                        vb,
  input  logic [IDX_W-1:0]            idx,
  input  logic [PMC_W-1:0]            pmc,
  output logic [XLEN-1:0]             rdata
);
  logic [IDX_W-1:0] slot;

  assign slot = addr[ADDR_W-2:1];

  always_comb begin
    rdata = '0;
    if (!addr[ADDR_W-1]) begin
      for (int s = 0; s < DEPTH; s++) begin
        if (slot == IDX_W'(s)) rdata = addr[0] ? dst_q[s] : src_q[s];
      end
    end else if (addr == CFG_ADDR) begin
      rdata = cfg_word(en, vb, idx, pmc);
    end
  end
endmodule

// File: rtl/branch_sample_recorder.sv
module branch_sample_recorder
  import brs_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int NUM_CNT = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               br_retire,
  input  logic [XLEN-1:0]    br_src,
  input  logic [XLEN-1:0]    br_dst,
  input  logic [NUM_CNT-1:0] cnt_ovf,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_we,
  input  logic [XLEN-1:0]    reg_wdata,
  output logic [XLEN-1:0]    reg_rdata,
  output logic               irq_out
);
  logic [1:0]             rst_sync;
  logic                   rst_sync_n;
  logic                   cfg_we, ent_we;
  logic                   cfg_en, cfg_vb, held_irq, rec_we;
  logic [IDX_W-1:0]       cfg_idx, rec_idx;
  logic [PMC_W-1:0]       cfg_pmc;
  logic [DEPTH-1:0][XLEN-1:0] src_q, dst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  assign cfg_we = reg_we && (reg_addr == CFG_ADDR);
  assign ent_we = reg_we && !reg_addr[ADDR_W-1];

  brs_ctrl #(.DEPTH(DEPTH), .NUM_CNT(NUM_CNT)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .cfg_we(cfg_we), .cfg_wdata(reg_wdata),
    .br_retire(br_retire), .cnt_ovf(cnt_ovf), .en_o(cfg_en), .vb_o(cfg_vb),
    .idx_o(cfg_idx), .pmc_o(cfg_pmc), .rec_we_o(rec_we), .rec_idx_o(rec_idx),
    .held_o(held_irq), .irq_o(irq_out)
  );

  brs_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_sync_n), .rec_we(rec_we), .rec_idx(rec_idx),
    .rec_src(br_src), .rec_dst(br_dst), .sw_we(ent_we),
    .sw_slot(reg_addr[ADDR_W-2:1]), .sw_sel_dst(reg_addr[0]),
    .sw_wdata(reg_wdata), .src_q(src_q), .dst_q(dst_q)
  );

  brs_rdmux #(.DEPTH(DEPTH)) u_rdmux (
    .addr(reg_addr), .src_q(src_q), .dst_q(dst_q), .en(cfg_en), .vb(cfg_vb),
    .idx(cfg_idx), .pmc(cfg_pmc), .rdata(reg_rdata)
  );
endmodule

// File: rtl/brs_checker.sv
module brs_checker
  import brs_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              br_retire,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [XLEN-1:0]   reg_wdata,
  input logic [XLEN-1:0]   reg_rdata,
  input logic              en,
  input logic              vb,
  input logic [IDX_W-1:0]  idx,
  input logic              held,
  input logic              irq_out
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);
  logic cfg_w;
  assign cfg_w = reg_we && (reg_addr == CFG_ADDR);

  assert_reserved_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == CFG_ADDR) |-> (reg_rdata[4:3] == 2'b11 && reg_rdata[63:27] == '0));

  assert_index_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (br_retire && en && !cfg_w && idx != LAST) |=> (idx == $past(idx) + IDX_W'(1) && vb));

  assert_valid_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vb && !cfg_w) |=> vb);

  assert_full_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (br_retire && en && !cfg_w && idx == LAST) |=> (!en && idx == '0));

  assert_idle_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cfg_w) |=> (!en && $stable(idx)));

  assert_no_irq_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> !en);

  assert_release_on_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (held && cfg_w && !reg_wdata[CFG_EN_BIT]) |=> irq_out);

  assert_target_top_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_addr[ADDR_W-1] && reg_addr[0]) |-> (reg_rdata[63:61] == 3'b000));
endmodule

bind branch_sample_recorder brs_checker #(.DEPTH(DEPTH)) u_brs_checker (
  .clk(clk), .rst_n(rst_sync_n), .br_retire(br_retire), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .en(cfg_en), .vb(cfg_vb), .idx(cfg_idx), .held(held_irq), .irq_out(irq_out)
);

// File: tb/branch_sample_recorder_bench.sv
module branch_sample_recorder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        br_retire = 1'b0;
  logic [63:0] br_src = '0, br_dst = '0;
  logic [5:0]  cnt_ovf = '0;
  logic [5:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  branch_sample_recorder u_branch_sample_recorder (
    .clk(clk), .rst_n(rst_n), .br_retire(br_retire), .br_src(br_src),
    .br_dst(br_dst), .cnt_ovf(cnt_ovf), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  // behavioural reference model
  bit          m_en, m_vb, m_hold, m_irq;
  int          m_idx, m_pmc;
  logic [63:0] m_src [16];
  logic [63:0] m_dst [16];

  function automatic logic [63:0] m_read(input logic [5:0] a);
    if (a < 32) return a[0] ? m_dst[a[4:1]] : m_src[a[4:1]];
    if (a == 32) return 64'h18 | (64'(m_en) << 2) | (64'(m_vb) << 5) |
                        (64'(m_idx) << 16) | (64'(m_pmc) << 24);
    return 64'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_vb = 0; m_hold = 0; m_irq = 0; m_idx = 0; m_pmc = 0;
      for (int k = 0; k < 16; k++) begin m_src[k] = '0; m_dst[k] = '0; end
    end else begin
      bit ovf;
      ovf = cnt_ovf[m_pmc] == 1'b1;
      if (reg_we && reg_addr == 32) begin
        m_en = reg_wdata[2]; m_vb = reg_wdata[5];
        m_idx = int'(reg_wdata[19:16]); m_pmc = int'(reg_wdata[26:24]);
      end else if (reg_we && reg_addr < 32) begin
        if (reg_addr[0]) m_dst[reg_addr[4:1]] = reg_wdata & 64'h1FFF_FFFF_FFFF_FFFF;
        else             m_src[reg_addr[4:1]] = reg_wdata;
      end
      if (br_retire && m_en) begin
        m_src[m_idx] = br_src;
        m_dst[m_idx] = br_dst & 64'h1FFF_FFFF_FFFF_FFFF;
        m_vb = 1;
        if (m_idx == 15) begin m_idx = 0; m_en = 0; end
        else m_idx = m_idx + 1;
      end
      m_irq  = (m_hold || ovf) && !m_en;
      m_hold = (m_hold || ovf) && m_en;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check("R6 model irq", 64'(irq_out), 64'(m_irq));
      check("R2 model read", reg_rdata, m_read(reg_addr));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic cyc(); @(posedge clk); #1; endtask
  task automatic wr(input logic [5:0] a, input logic [63:0] d);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d; cyc(); reg_we = 1'b0;
  endtask
  task automatic br(input logic [63:0] s, input logic [63:0] d);
    br_retire = 1'b1; br_src = s; br_dst = d; cyc(); br_retire = 1'b0;
  endtask
  task automatic rd_chk(input string tag, input logic [5:0] a, input logic [63:0] e);
    #1 reg_addr = a; @(negedge clk); check(tag, reg_rdata, e);
  endtask
  task automatic irq_chk(input string tag, input logic e);
    @(negedge clk); check(tag, 64'(irq_out), 64'(e));
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (4) cyc();

    // R1 reset state
    rd_chk("R1 cfg", 6'd32, 64'h18);
    irq_chk("R1 irq", 1'b0);
    rd_chk("R1 src0", 6'd0, 64'h0);
    rd_chk("R1 dst0", 6'd1, 64'h0);

    // R2 field placement
    wr(6'd32, 64'hFFFF_FFFF_FFFF_FFFB);
    rd_chk("R2 all fields", 6'd32, 64'h0000_0000_070F_0038);
    wr(6'd32, 64'h0300_0000);
    rd_chk("R2 select only", 6'd32, 64'h0300_0018);

    // R9 overflow while disabled
    cnt_ovf = 6'b000100; cyc(); cnt_ovf = '0;
    irq_chk("R9 other line", 1'b0);
    cnt_ovf = 6'b001000; cyc(); cnt_ovf = '0;
    irq_chk("R9 pulse", 1'b1);
    irq_chk("R9 pulse end", 1'b0);

    // R6 overflow held across a capture
    cnt_ovf = 6'b001000; wr(6'd32, 64'h0300_0004); cnt_ovf = '0;
    irq_chk("R6 held", 1'b0);
    rd_chk("R6 armed", 6'd32, 64'h0300_001C);
    for (int i = 0; i < 5; i++) br(64'h1000 + 64'(i), 64'hE000_0000_0000_2000 + 64'(i));
    rd_chk("R4 index 5", 6'd32, 64'h0305_003C);
    rd_chk("R3 src slot2", 6'd4, 64'h1002);
    rd_chk("R8 dst slot2", 6'd5, 64'h2002);
    for (int i = 5; i < 15; i++) begin
      br(64'h1000 + 64'(i), 64'hE000_0000_0000_2000 + 64'(i));
      if (i % 3 == 0) cyc();
    end
    irq_chk("R6 still held", 1'b0);
    rd_chk("R4 index 15", 6'd32, 64'h030F_003C);
    br(64'h100F, 64'hE000_0000_0000_200F);
    irq_chk("R6 release on full", 1'b1);
    rd_chk("R5 full cfg", 6'd32, 64'h0300_0038);
    irq_chk("R6 single pulse", 1'b0);
    br(64'hDEAD, 64'hBEEF);
    rd_chk("R5 slot0 kept", 6'd0, 64'h1000);
    rd_chk("R5 cfg frozen", 6'd32, 64'h0300_0038);
    rd_chk("R3 src slot15", 6'd30, 64'h100F);
    rd_chk("R3 dst slot15", 6'd31, 64'h200F);

    // R7 software stop releases the held interrupt
    cnt_ovf = 6'b001000; wr(6'd32, 64'h0300_0004); cnt_ovf = '0;
    for (int i = 0; i < 3; i++) br(64'h3000 + 64'(i), 64'h4000 + 64'(i));
    irq_chk("R7 held", 1'b0);
    wr(6'd32, 64'h0303_0020);
    irq_chk("R7 release", 1'b1);
    rd_chk("R7 fields kept", 6'd32, 64'h0303_0038);
    rd_chk("R7 new slot2", 6'd4, 64'h3002);
    rd_chk("R7 old slot3", 6'd6, 64'h1003);

    // R10 write and branch in one cycle
    br_retire = 1'b1; br_src = 64'h5000; br_dst = 64'h6000;
    wr(6'd32, 64'h0307_0004); br_retire = 1'b0;
    rd_chk("R10 enable write", 6'd32, 64'h0308_003C);
    rd_chk("R10 slot7", 6'd14, 64'h5000);
    br_retire = 1'b1; br_src = 64'hBAD; br_dst = 64'hBAD;
    wr(6'd32, 64'h0308_0020); br_retire = 1'b0;
    rd_chk("R10 disable write", 6'd16, 64'h1008);
    rd_chk("R10 cfg", 6'd32, 64'h0308_0038);

    // R11 software slot writes
    wr(6'd7, 64'hFFFF_FFFF_FFFF_FFFE);
    rd_chk("R11 R8 marker", 6'd7, 64'h1FFF_FFFF_FFFF_FFFE);
    wr(6'd6, 64'h77);
    rd_chk("R11 src write", 6'd6, 64'h77);
    wr(6'd40, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_chk("R11 unmapped", 6'd40, 64'h0);
    rd_chk("R11 cfg untouched", 6'd32, 64'h0308_0038);
    rd_chk("R11 slot4 untouched", 6'd8, 64'h1004);

    repeat (2) cyc();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule